// File: doc/BRIEF.md
# Calibration and Conversion Sequencer

This block sequences the jobs of a delta-sigma measurement channel. Software writes a configuration word that holds a 3-bit calibration code, a 3-bit word-rate field and a continuous-mode bit. It also sends 8-bit command bytes. A non-zero, valid calibration code starts a calibration job. The job is either offset or gain, either self or system, or a chained offset-then-gain self calibration. A specific command byte starts a conversion.

For every job, the sequencer sends a one-cycle start strobe to an external modulator and filter model. The strobe carries the job kind, the self/system choice, the word rate and a flag marking the first conversion of a run. The sequencer then waits for the model's done pulse. When the pulse arrives, it stores the returned value in the offset, gain or data register and raises a done flag in the configuration word.

The first conversion of a run is flagged so that the model can take its longer settling time. In continuous mode, later conversions are restarted right away with the flag low. The registers are read through a combinational read port. Reading the data register clears the done flag.

Top module: `cal_conv_seq`

## Requirements
- R1: After reset, busy and mod_start are 0. The configuration word reads 0. The offset and data registers read 0. The gain register reads 2^(DW-2), which is 0x400000 for DW=24.
- R2: A configuration write of calibration code 001 (bits [2:0]) while idle causes the following:
  - mod_start pulses for exactly one cycle, starting on the cycle after the write, with mod_kind=1 (offset) and mod_sys=0.
  - On mod_done, the offset register takes mod_value.
  - The calibration field then reads 000, the done flag (configuration bit 7) reads 1, and busy returns to 0.
- R3: Calibration code 010 starts a job with mod_kind=2 (gain) and mod_sys=0. On mod_done, mod_value goes to the gain register, the calibration field returns to 000 and the done flag is set.
- R4: Calibration code 011 runs in two steps. It first starts an offset job (mod_kind=1). On the cycle after that job's mod_done, it starts a gain job (mod_kind=2) with busy still 1. Each step's value goes to its own register. The done flag is set only after the gain step.
- R5: Codes 101 and 110 behave like 001 and 010, but with mod_sys=1.
- R6: Codes 000, 100 and 111 start nothing: busy and mod_start stay 0. The calibration field reads back the written code.
- R7: Command byte 0xC0 while idle starts a conversion. Bit 7 is the command bit and bit 6 is the single-conversion bit; all other bits are 0.
  - The conversion has mod_kind=0, mod_first=1 and mod_rate equal to configuration bits [5:3].
  - On mod_done, the data register takes mod_value, the done flag is set and busy returns to 0.
  - Other bytes, such as 0xC1 and 0x40, start nothing.
- R8: With configuration bit 6 set, each conversion's mod_done stores the data and restarts a conversion on the next cycle with mod_first=0. Stop command 0x80, accepted while converting, ends the run after the conversion in progress.
- R9: A read strobe with rd_sel=3 (data) clears the done flag. A read of rd_sel=0 (offset), 1 (gain) or 2 (configuration) leaves it unchanged.
- R10: While busy, configuration writes and command bytes other than 0x80 are ignored. Neither the configuration word nor the job in progress changes.
- R11: A mod_done pulse while idle changes no register and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration word: [2:0] calibration code, [5:3] word rate, [6] continuous |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| rd_en | input | 1 | Read strobe (a data read clears the done flag) |
| rd_sel | input | 2 | Register select: 0 offset, 1 gain, 2 configuration, 3 data |
| rd_data | output | DW | Selected register, combinational |
| busy | output | 1 | A job is in progress |
| mod_start | output | 1 | One-cycle start strobe to the modulator model |
| mod_kind | output | 2 | Job kind: 0 conversion, 1 offset, 2 gain |
| mod_sys | output | 1 | 1 for a system calibration |
| mod_first | output | 1 | First conversion of a run |
| mod_rate | output | 3 | Word-rate selection for the job |
| mod_done | input | 1 | Model completion pulse |
| mod_value | input | DW | Value returned with mod_done |

## Verification
The assertions assume that the model raises mod_done only while a job is waiting, and never in the same cycle as mod_start. They also assume that the strobes last a single cycle. The stimulus keeps to these assumptions because it drives every strobe for exactly one cycle on the falling edge. It also raises mod_done no earlier than the cycle after the start strobe has dropped. Ignored-input cases are made deliberately: a done pulse while idle, and configuration writes and commands while busy. They are then judged by reading the registers back through the read port.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int CAL_LSB  = 0;
    localparam int RATE_LSB = 3;
    localparam int CONT_BIT = 6;
    localparam int CFG_W    = 7;

    typedef enum logic [1:0] {ST_IDLE, ST_OFS, ST_GAIN, ST_CONV} seq_state_e;
    typedef enum logic [1:0] {JOB_CONV = 2'd0, JOB_OFS = 2'd1, JOB_GAIN = 2'd2} job_kind_e;

    typedef struct packed {
        logic go_ofs;
        logic go_gain;
        logic chain;
        logic sys;
    } cal_plan_t;
endpackage

// File: rtl/seq_cal_decode.sv
module seq_cal_decode
    import seq_pkg::*;
(
    input  logic [2:0] code,
    output cal_plan_t  plan
);
    always_comb begin
        plan = '0;
        case (code)
            3'b001: plan.go_ofs = 1'b1;
            3'b010: plan.go_gain = 1'b1;
            3'b011: begin plan.go_ofs = 1'b1; plan.chain = 1'b1; end
            3'b101: begin plan.go_ofs = 1'b1; plan.sys = 1'b1; end
            3'b110: begin plan.go_gain = 1'b1; plan.sys = 1'b1; end
            default: plan = '0;
        endcase
    end
endmodule

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode #(
    parameter int CMD_W = 8
) (
    input  logic [CMD_W-1:0] cmd_byte,
    output logic             is_single,
    output logic             is_stop
);
    localparam int CB_POS = CMD_W - 1;
    localparam int SC_POS = CMD_W - 2;
    localparam logic [CMD_W-1:0] SINGLE_CODE = (CMD_W'(1) << CB_POS) | (CMD_W'(1) << SC_POS);
    localparam logic [CMD_W-1:0] STOP_CODE   = CMD_W'(1) << CB_POS;

    assign is_single = (cmd_byte == SINGLE_CODE);
    assign is_stop   = (cmd_byte == STOP_CODE);
endmodule

// File: rtl/seq_rd_mux.sv
module seq_rd_mux #(
    parameter int DW = 24,
    parameter int CW = 8
) (
    input  logic [1:0]    sel,
    input  logic [DW-1:0] ofs,
    input  logic [DW-1:0] gain,
    input  logic [DW-1:0] data,
    input  logic [CW-1:0] cfg_word,
    output logic [DW-1:0] rd_data
);
    localparam int PAD = DW - CW;

    always_comb begin
        case (sel)
            2'd0:    rd_data = ofs;
            2'd1:    rd_data = gain;
            2'd2:    rd_data = {{PAD{1'b0}}, cfg_word};
            default: rd_data = data;
        endcase
    end
endmodule

// File: rtl/cal_conv_seq.sv
module cal_conv_seq
    import seq_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_byte,
    input  logic                rd_en,
    input  logic [1:0]          rd_sel,
    output logic [DW-1:0]       rd_data,
    output logic                busy,
    output logic                mod_start,
    output logic [1:0]          mod_kind,
    output logic                mod_sys,
    output logic                mod_first,
    output logic [2:0]          mod_rate,
    input  logic                mod_done,
    input  logic [DW-1:0]       mod_value
);
    localparam logic [DW-1:0] GAIN_RST = DW'(1) << (DW - 2);

    typedef struct packed {
        seq_state_e       st;
        logic             start;
        job_kind_e        kind;
        logic             sys;
        logic             first;
        logic             chain;
        logic             stop;
        logic [2:0]       rate;
        logic [CFG_W-1:0] cfg;
        logic             done;
        logic [DW-1:0]    ofs;
        logic [DW-1:0]    gain;
        logic [DW-1:0]    data;
    } seq_reg_t;

    localparam seq_reg_t RST = '{st: ST_IDLE, start: 1'b0, kind: JOB_CONV, sys: 1'b0,
                                 first: 1'b0, chain: 1'b0, stop: 1'b0, rate: 3'd0,
                                 cfg: '0, done: 1'b0, ofs: '0, gain: GAIN_RST, data: '0};

    seq_reg_t  q, d;
    cal_plan_t plan;
    logic      cmd_single, cmd_stop;
    logic      done_flag;
    logic [CFG_W-1:0] cfg_low;

    seq_cal_decode u_cal (.code(cfg_wdata[CAL_LSB +: 3]), .plan(plan));
    seq_cmd_decode #(.CMD_W(8)) u_cmd (.cmd_byte(cmd_byte), .is_single(cmd_single), .is_stop(cmd_stop));

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (rd_en && rd_sel == 2'd3) d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cfg_wr) begin
                    d.cfg = cfg_wdata;
                    if (plan.go_ofs || plan.go_gain) begin
                        d.st    = plan.go_ofs ? ST_OFS : ST_GAIN;
                        d.kind  = plan.go_ofs ? JOB_OFS : JOB_GAIN;
                        d.start = 1'b1;
                        d.sys   = plan.sys;
                        d.chain = plan.chain;
                        d.first = 1'b0;
                        d.rate  = cfg_wdata[RATE_LSB +: 3];
                        d.done  = 1'b0;
                    end
                end else if (cmd_valid && cmd_single) begin
                    d.st    = ST_CONV;
                    d.kind  = JOB_CONV;
                    d.start = 1'b1;
                    d.sys   = 1'b0;
                    d.first = 1'b1;
                    d.stop  = 1'b0;
                    d.rate  = q.cfg[RATE_LSB +: 3];
                    d.done  = 1'b0;
                end
            end
            ST_OFS: begin
                if (mod_done) begin
                    d.ofs = mod_value;
                    if (q.chain) begin
                        d.st    = ST_GAIN;
                        d.kind  = JOB_GAIN;
                        d.start = 1'b1;
                        d.chain = 1'b0;
                    end else begin
                        d.st                 = ST_IDLE;
                        d.cfg[CAL_LSB +: 3]  = 3'b000;
                        d.done               = 1'b1;
                    end
                end
            end
            ST_GAIN: begin
                if (mod_done) begin
                    d.gain               = mod_value;
                    d.st                 = ST_IDLE;
                    d.cfg[CAL_LSB +: 3]  = 3'b000;
                    d.done               = 1'b1;
                end
            end
            default: begin
                if (cmd_valid && cmd_stop) d.stop = 1'b1;
                if (mod_done) begin
                    d.data = mod_value;
                    d.done = 1'b1;
                    if (q.cfg[CONT_BIT] && !d.stop) begin
                        d.start = 1'b1;
                        d.first = 1'b0;
                    end else begin
                        d.st   = ST_IDLE;
                        d.stop = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign done_flag = q.done;
    assign cfg_low   = q.cfg;
    assign busy      = (q.st != ST_IDLE);
    assign mod_start = q.start;
    assign mod_kind  = q.kind;
    assign mod_sys   = q.sys;
    assign mod_first = q.first;
    assign mod_rate  = q.rate;

    seq_rd_mux #(.DW(DW), .CW(CFG_W + 1)) u_rd (
        .sel(rd_sel), .ofs(q.ofs), .gain(q.gain), .data(q.data),
        .cfg_word({done_flag, cfg_low}), .rd_data(rd_data)
    );
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
    parameter int CFG_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mod_start,
    input logic [1:0]       mod_kind,
    input logic             mod_first,
    input logic             mod_done,
    input logic             cfg_wr,
    input logic             cmd_valid,
    input logic             rd_en,
    input logic [1:0]       rd_sel,
    input logic             done_flag,
    input logic [CFG_W-1:0] cfg_low
);
    p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mod_start |=> !mod_start);

    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mod_start |-> busy);

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr && !mod_done) |=> $stable(cfg_low));

    p_flag_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(mod_done));

    p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'd3 && !mod_done) |=> !done_flag);

    p_idle_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mod_done && !cfg_wr && !cmd_valid) |=> (!busy && !mod_start));

    p_later_conv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_start && mod_kind == 2'd0 && !mod_first) |-> $past(mod_done));
endmodule

bind cal_conv_seq seq_chk #(.CFG_W(seq_pkg::CFG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mod_start(mod_start),
    .mod_kind(mod_kind), .mod_first(mod_first), .mod_done(mod_done),
    .cfg_wr(cfg_wr), .cmd_valid(cmd_valid), .rd_en(rd_en), .rd_sel(rd_sel),
    .done_flag(done_flag), .cfg_low(cfg_low)
);

// File: tb/sim_cal_conv_seq.sv
module sim_cal_conv_seq;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [6:0]    cfg_wdata = '0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_byte = '0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_sel = '0;
    logic [DW-1:0] rd_data;
    logic          busy, mod_start, mod_sys, mod_first;
    logic [1:0]    mod_kind;
    logic [2:0]    mod_rate;
    logic          mod_done = 1'b0;
    logic [DW-1:0] mod_value = '0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cal_conv_seq #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .busy(busy), .mod_start(mod_start), .mod_kind(mod_kind),
        .mod_sys(mod_sys), .mod_first(mod_first), .mod_rate(mod_rate),
        .mod_done(mod_done), .mod_value(mod_value)
    );

    // entry: code[7:5], number of starts[4:3], first kind[2:1], sys[0]
    localparam logic [7:0] CAL_TAB [8] = '{
        {3'd0, 2'd0, 2'd0, 1'b0},
        {3'd1, 2'd1, 2'd1, 1'b0},
        {3'd2, 2'd1, 2'd2, 1'b0},
        {3'd3, 2'd2, 2'd1, 1'b0},
        {3'd4, 2'd0, 2'd0, 1'b0},
        {3'd5, 2'd1, 2'd1, 1'b1},
        {3'd6, 2'd1, 2'd2, 1'b1},
        {3'd7, 2'd0, 2'd0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [6:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] v);
        @(negedge clk); cmd_valid = 1'b1; cmd_byte = v;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic done_pulse(input logic [DW-1:0] v);
        @(negedge clk); mod_done = 1'b1; mod_value = v;
        @(negedge clk); mod_done = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [DW-1:0] v);
        @(negedge clk); rd_sel = sel; #1 v = rd_data;
    endtask

    task automatic rd_strobe(input logic [1:0] sel);
        @(negedge clk); rd_en = 1'b1; rd_sel = sel;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 mod_start", mod_start, 0);
        rd(2'd0, v); check("R1 offset", v, 0);
        rd(2'd1, v); check("R1 gain", v, 32'h400000);
        rd(2'd2, v); check("R1 config", v, 0);
        rd(2'd3, v); check("R1 data", v, 0);

        // R11 done pulse while idle
        done_pulse(24'hABCDEF);
        check("R11 busy", busy, 0);
        check("R11 start", mod_start, 0);
        rd(2'd3, v); check("R11 data", v, 0);
        rd(2'd0, v); check("R11 offset", v, 0);
        rd(2'd2, v); check("R11 config", v, 0);

        // calibration code table
        for (int i = 0; i < 8; i++) begin
            logic [7:0] e;
            logic [2:0] code;
            logic [1:0] n, k;
            logic s;
            logic [DW-1:0] val1, val2;
            string tg;
            e = CAL_TAB[i];
            code = e[7:5]; n = e[4:3]; k = e[2:1]; s = e[0];
            val1 = 24'h100000 + DW'(i * 24'h111);
            val2 = 24'h380000 - DW'(i * 24'h23);
            tg = (n == 2) ? "R4" : (s ? "R5" : (k == 1 ? "R2" : "R3"));
            cfg_write({1'b0, 3'(7 - i), code});
            if (n == 0) begin
                check("R6 busy", busy, 0);
                check("R6 start", mod_start, 0);
                rd(2'd2, v); check("R6 code", v[2:0], code);
            end else begin
                check({tg, " start"}, mod_start, 1);
                check({tg, " kind"}, mod_kind, k);
                check({tg, " sys"}, mod_sys, s);
                @(negedge clk);
                check({tg, " pulse"}, mod_start, 0);
                done_pulse(val1);
                if (n == 2) begin
                    check("R4 second start", mod_start, 1);
                    check("R4 second kind", mod_kind, 2);
                    check("R4 busy", busy, 1);
                    rd(2'd2, v); check("R4 flag mid", v[7], 0);
                    done_pulse(val2);
                    rd(2'd0, v); check("R4 offset", v, val1);
                    rd(2'd1, v); check("R4 gain", v, val2);
                end else begin
                    rd((k == 1) ? 2'd0 : 2'd1, v); check({tg, " value"}, v, val1);
                end
                check({tg, " idle"}, busy, 0);
                rd(2'd2, v);
                check({tg, " code cleared"}, v[2:0], 0);
                check({tg, " flag"}, v[7], 1);
            end
        end

        // R7 single conversion, rate 2, not continuous
        cfg_write(7'b0_010_000);
        send_cmd(8'hC1); check("R7 C1 ignored", busy, 0);
        send_cmd(8'h40); check("R7 40 ignored", busy, 0);
        send_cmd(8'hC0);
        check("R7 start", mod_start, 1);
        check("R7 kind", mod_kind, 0);
        check("R7 first", mod_first, 1);
        check("R7 rate", mod_rate, 2);
        done_pulse(24'h0F0F0F);
        check("R7 idle", busy, 0);
        check("R7 no restart", mod_start, 0);
        rd(2'd3, v); check("R7 data", v, 24'h0F0F0F);
        rd(2'd2, v); check("R7 flag", v[7], 1);

        // R9 read-clear
        rd_strobe(2'd0);
        rd(2'd2, v); check("R9 offset read keeps flag", v[7], 1);
        rd_strobe(2'd3);
        rd(2'd2, v); check("R9 data read clears flag", v[7], 0);

        // R10 writes and commands ignored while busy
        send_cmd(8'hC0);
        check("R10 busy", busy, 1);
        cfg_write(7'b1_000_101);
        check("R10 no cal start", mod_start, 0);
        send_cmd(8'hC0);
        check("R10 no second start", mod_start, 0);
        rd(2'd2, v); check("R10 config held", v, 32'h10);
        done_pulse(24'h00BEEF);
        check("R10 idle", busy, 0);
        rd(2'd3, v); check("R10 data", v, 24'h00BEEF);

        // R8 continuous, rate 5
        cfg_write(7'b1_101_000);
        send_cmd(8'hC0);
        check("R8 first", mod_first, 1);
        check("R8 rate", mod_rate, 5);
        done_pulse(24'h000111);
        check("R8 restart", mod_start, 1);
        check("R8 later first", mod_first, 0);
        check("R8 busy", busy, 1);
        done_pulse(24'h000222);
        check("R8 restart2", mod_start, 1);
        rd(2'd3, v); check("R8 data2", v, 24'h000222);
        send_cmd(8'h80);
        check("R8 still busy", busy, 1);
        done_pulse(24'h000333);
        check("R8 stopped", busy, 0);
        check("R8 no restart", mod_start, 0);
        rd(2'd3, v); check("R8 data3", v, 24'h000333);

        finish_run();
    end
endmodule